// File: doc/BRIEF.md
# Sleep and Wake Request Controller

This block decides when the device leaves its full-power state for a low-power state and when it comes back. It watches a sleep control pin, a mask bit, a polarity bit and a summary flag that says some unmasked interrupt is pending. From these it launches power sequences by pulsing one of three start strobes: active-to-sleep, sleep-to-active or sleep-to-off. It then waits for a completion handshake from the external power sequencer before it accepts anything new.

The pin is brought into the clock domain through a two-flop synchronizer. Only the synchronized, polarity-corrected and mask-qualified level reaches the state machine. The sleep level is active low when the polarity bit is 0. A sleep request is refused for as long as an unmasked interrupt is pending. Once asleep, the block wakes on a pending interrupt or on the pin returning to its inactive level. A select input, sampled at the moment of wake, picks whether the wake sequence ends in the full-power state or in the off state. The off state is left only through reset.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: After reset, `powerState` is 0 (ACTIVE) and all three strobes are low.
- R2: With `polInvert`=0, `sleepMask`=0 and `irqPending`=0, a low `sleepPin` takes the block from ACTIVE to state 1 (GOING_TO_SLEEP), and `seqActToSlp` pulses. Both are seen after the third rising edge that follows the pin change.
- R3: With `polInvert`=1 the sense is reversed: a high pin requests sleep and a low pin does not.
- R4: While `sleepMask`=1, the block does not leave ACTIVE because of the pin.
- R5: While `irqPending`=1, the block does not leave ACTIVE.
- R6: State 1 (GOING_TO_SLEEP) and state 3 (WAKING) are held until `seqDone` is high at a rising edge. From state 1 the block then enters state 2 (SLEEP).
- R7: In SLEEP, `irqPending`=1 starts a wake on the next edge. Wake strobes never fire outside SLEEP.
- R8: In SLEEP, the sleep request going inactive (pin high with `polInvert`=0) starts a wake.
- R9: At wake, `offSelect`=0 pulses `seqSlpToAct`, and `seqDone` then returns the block to ACTIVE. At wake, `offSelect`=1 pulses `seqSlpToOff`, and `seqDone` then enters state 4 (OFF). OFF is held until reset.
- R10: Each strobe is high for one cycle only, and never more than one strobe is high at a time. A strobe coincides with the first cycle of the state it launches.
- R11: Request changes while in state 1 or state 3 produce no strobe and no state change.
- R12: `seqDone` has no effect in ACTIVE or SLEEP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sleepPin | input | 1 | Asynchronous sleep control pin |
| polInvert | input | 1 | 0: pin low requests sleep; 1: pin high requests sleep |
| sleepMask | input | 1 | 1: the pin cannot request sleep |
| irqPending | input | 1 | Some unmasked interrupt is pending |
| offSelect | input | 1 | Sampled at wake: 1 selects the sleep-to-off path |
| seqDone | input | 1 | The power sequencer has finished the running sequence |
| seqActToSlp | output | 1 | One-cycle start of the active-to-sleep sequence |
| seqSlpToAct | output | 1 | One-cycle start of the sleep-to-active sequence |
| seqSlpToOff | output | 1 | One-cycle start of the sleep-to-off sequence |
| powerState | output | 3 | 0 ACTIVE, 1 GOING_TO_SLEEP, 2 SLEEP, 3 WAKING, 4 OFF |

## Verification
Directed steps first separate the cases that hold the block in ACTIVE (masked pin, pending interrupt, wrong polarity) from the one that lets it fall asleep. They then drive both wake causes and both wake destinations, and they toggle the pin and `seqDone` where these must be ignored. A random phase then varies the pin, mask, polarity, interrupt and select inputs, while a sequencer model answers each strobe after a random delay and also injects stray done pulses. Each cycle is compared against a bench model of the state transitions. This shows whether a request that arrives during a running sequence, or a stray done, can leak into the state or the strobes.

// File: rtl/pwr_sleep_pkg.sv
`timescale 1ns/1ps
package pwr_sleep_pkg;
  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    PS_ACTIVE   = 3'd0,
    PS_TO_SLEEP = 3'd1,
    PS_SLEEP    = 3'd2,
    PS_WAKING   = 3'd3,
    PS_OFF      = 3'd4
  } pwr_state_e;

  typedef struct packed {
    logic actToSlp;
    logic slpToAct;
    logic slpToOff;
  } seq_kick_t;
endpackage

// File: rtl/sleep_sync_path.sv
`timescale 1ns/1ps
// Pin conditioning and strobe output registers.
module sleep_sync_path
  import pwr_sleep_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sleepPin,
  input  logic      polInvert,
  input  logic      sleepMask,
  input  seq_kick_t kickNext,
  output logic      sleepReq,
  output seq_kick_t kickQ
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] syncQ;
  logic [TOP:0] fillQ;
  logic         pinLevel;
  logic         asserted;

  generate
    if (SYNC_STAGES < 2) begin : g_bad
      initial $error("SYNC_STAGES must be at least 2");
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      fillQ <= '0;
      kickQ <= '0;
    end else begin
      syncQ <= {syncQ[TOP-1:0], sleepPin};
      fillQ <= {fillQ[TOP-1:0], 1'b1};
      kickQ <= kickNext;
    end
  end

  assign pinLevel = syncQ[TOP];
  assign asserted = polInvert ? pinLevel : ~pinLevel;
  // No request until the synchronizer holds real pin samples.
  assign sleepReq = fillQ[TOP] & asserted & ~sleepMask;
endmodule

// File: rtl/sleep_state_ctrl.sv
`timescale 1ns/1ps
// Power state machine; emits start strobes as a struct.
module sleep_state_ctrl
  import pwr_sleep_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sleepReq,
  input  logic       irqPending,
  input  logic       offSelect,
  input  logic       seqDone,
  output seq_kick_t  kickNext,
  output pwr_state_e stateQ
);
  pwr_state_e stateNext;
  logic       toOffQ;
  logic       wakeNow;

  assign wakeNow = irqPending | ~sleepReq;

  always_comb begin
    stateNext = stateQ;
    kickNext  = '0;
    unique case (stateQ)
      PS_ACTIVE: begin
        if (sleepReq && !irqPending) begin
          stateNext         = PS_TO_SLEEP;
          kickNext.actToSlp = 1'b1;
        end
      end
      PS_TO_SLEEP: if (seqDone) stateNext = PS_SLEEP;
      PS_SLEEP: begin
        if (wakeNow) begin
          stateNext = PS_WAKING;
          if (offSelect) kickNext.slpToOff = 1'b1;
          else           kickNext.slpToAct = 1'b1;
        end
      end
      PS_WAKING: if (seqDone) stateNext = toOffQ ? PS_OFF : PS_ACTIVE;
      PS_OFF: stateNext = PS_OFF;
      default: stateNext = PS_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= PS_ACTIVE;
      toOffQ <= 1'b0;
    end else begin
      stateQ <= stateNext;
      if (stateQ == PS_SLEEP && wakeNow) toOffQ <= offSelect;
    end
  end
endmodule

// File: rtl/pwr_sleep_ctrl.sv
`timescale 1ns/1ps
module pwr_sleep_ctrl
  import pwr_sleep_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sleepPin,
  input  logic               polInvert,
  input  logic               sleepMask,
  input  logic               irqPending,
  input  logic               offSelect,
  input  logic               seqDone,
  output logic               seqActToSlp,
  output logic               seqSlpToAct,
  output logic               seqSlpToOff,
  output logic [STATE_W-1:0] powerState
);
  seq_kick_t  kickNext;
  seq_kick_t  kickQ;
  logic       sleepReq;
  pwr_state_e stateQ;

  sleep_sync_path #(.SYNC_STAGES(SYNC_STAGES)) u_path (
    .clk(clk), .rstN(rstN), .sleepPin(sleepPin), .polInvert(polInvert),
    .sleepMask(sleepMask), .kickNext(kickNext), .sleepReq(sleepReq),
    .kickQ(kickQ)
  );

  sleep_state_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .irqPending(irqPending),
    .offSelect(offSelect), .seqDone(seqDone), .kickNext(kickNext),
    .stateQ(stateQ)
  );

  assign seqActToSlp = kickQ.actToSlp;
  assign seqSlpToAct = kickQ.slpToAct;
  assign seqSlpToOff = kickQ.slpToOff;
  assign powerState  = stateQ;
endmodule

// File: rtl/sleep_ctrl_checker.sv
`timescale 1ns/1ps
module sleep_ctrl_checker
  import pwr_sleep_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               sleepMask,
  input logic               irqPending,
  input logic               seqDone,
  input logic               seqActToSlp,
  input logic               seqSlpToAct,
  input logic               seqSlpToOff,
  input logic [STATE_W-1:0] powerState
);
  logic anyKick;
  logic busy;
  assign anyKick = seqActToSlp | seqSlpToAct | seqSlpToOff;
  assign busy    = (powerState == PS_TO_SLEEP) || (powerState == PS_WAKING);

  assert_strobe_onehot_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({seqActToSlp, seqSlpToAct, seqSlpToOff}));
  assert_strobe_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    anyKick |=> !anyKick);
  assert_a2s_entry_R2: assert property (@(posedge clk) disable iff (!rstN)
    seqActToSlp |-> powerState == PS_TO_SLEEP);
  assert_mask_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (powerState == PS_ACTIVE && sleepMask) |=> powerState == PS_ACTIVE);
  assert_irq_block_R5: assert property (@(posedge clk) disable iff (!rstN)
    (powerState == PS_ACTIVE && irqPending) |=> powerState == PS_ACTIVE);
  assert_hold_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !seqDone) |=> $stable(powerState));
  assert_wake_in_sleep_R7: assert property (@(posedge clk) disable iff (!rstN)
    (powerState != PS_SLEEP) |=> !(seqSlpToAct || seqSlpToOff));
  assert_off_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (powerState == PS_OFF) |=> powerState == PS_OFF);
  assert_no_kick_busy_R11: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !anyKick);
  assert_done_idle_R12: assert property (@(posedge clk) disable iff (!rstN)
    (powerState == PS_SLEEP && seqDone && !irqPending) |=>
      (powerState == PS_SLEEP || powerState == PS_WAKING));
endmodule

bind pwr_sleep_ctrl sleep_ctrl_checker u_chk (
  .clk(clk), .rstN(rstN), .sleepMask(sleepMask), .irqPending(irqPending),
  .seqDone(seqDone), .seqActToSlp(seqActToSlp), .seqSlpToAct(seqSlpToAct),
  .seqSlpToOff(seqSlpToOff), .powerState(powerState)
);

// File: tb/sim_pwr_sleep_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_sleep_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sleepPin = 1'b1, polInvert = 1'b0, sleepMask = 1'b1;
  logic irqPending = 1'b0, offSelect = 1'b0, seqDone = 1'b0;
  logic seqActToSlp, seqSlpToAct, seqSlpToOff;
  logic [2:0] powerState;
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pwr_sleep_ctrl u0 (
    .clk(clk), .rstN(rstN), .sleepPin(sleepPin), .polInvert(polInvert),
    .sleepMask(sleepMask), .irqPending(irqPending), .offSelect(offSelect),
    .seqDone(seqDone), .seqActToSlp(seqActToSlp), .seqSlpToAct(seqSlpToAct),
    .seqSlpToOff(seqSlpToOff), .powerState(powerState)
  );

  // Reference model of the requirements (state codes as in R1..R9).
  logic [1:0] mSync, mFill;
  logic [2:0] mState;
  logic [2:0] mKick;   // {actToSlp, slpToAct, slpToOff}
  logic       mToOff;
  function automatic logic reqOf(logic [1:0] s, logic [1:0] f, logic inv, logic msk);
    return f[1] && (inv ? s[1] : ~s[1]) && !msk;
  endfunction
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mSync <= 2'b00; mFill <= 2'b00; mState <= 3'd0; mKick <= 3'b000; mToOff <= 1'b0;
    end else begin
      logic r;
      r = reqOf(mSync, mFill, polInvert, sleepMask);
      mSync <= {mSync[0], sleepPin};
      mFill <= {mFill[0], 1'b1};
      mKick <= 3'b000;
      case (mState)
        3'd0: if (r && !irqPending) begin mState <= 3'd1; mKick <= 3'b100; end
        3'd1: if (seqDone) mState <= 3'd2;
        3'd2: if (irqPending || !r) begin
                mState <= 3'd3; mToOff <= offSelect;
                mKick <= offSelect ? 3'b001 : 3'b010;
              end
        3'd3: if (seqDone) mState <= mToOff ? 3'd4 : 3'd0;
        default: mState <= mState;
      endcase
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int kicks();
    return {seqActToSlp, seqSlpToAct, seqSlpToOff};
  endfunction

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0; seqDone = 1'b0;
    cyc(2); rstN = 1'b1;
  endtask

  task automatic pulseDone();
    seqDone = 1'b1; @(negedge clk); seqDone = 1'b0;
  endtask

  initial begin
    int seed;
    int pend;
    seed = 32'h5EED1234;
    void'($urandom(seed));
    cyc(2); rstN = 1'b1;
    cyc(1);
    chk("R1 state", powerState, 0);
    chk("R1 strobes", kicks(), 0);

    sleepPin = 1'b0; cyc(6);
    chk("R4 masked stays active", powerState, 0);
    sleepMask = 1'b0; irqPending = 1'b1; cyc(6);
    chk("R5 irq blocks sleep", powerState, 0);
    irqPending = 1'b0; cyc(1);
    chk("R2 enter going-to-sleep", powerState, 1);
    chk("R2 act-to-sleep strobe", kicks(), 3'b100);
    cyc(1);
    chk("R10 strobe single cycle", kicks(), 0);
    sleepPin = 1'b1; irqPending = 1'b1; cyc(5);
    chk("R11 busy ignores requests", powerState, 1);
    chk("R11 no strobe while busy", kicks(), 0);
    sleepPin = 1'b0; irqPending = 1'b0; cyc(4);
    chk("R6 held without done", powerState, 1);
    pulseDone();
    chk("R6 done enters sleep", powerState, 2);
    pulseDone(); cyc(1);
    chk("R12 done ignored in sleep", powerState, 2);
    offSelect = 1'b0; irqPending = 1'b1; cyc(1);
    chk("R7 irq wake", powerState, 3);
    chk("R9 sleep-to-active strobe", kicks(), 3'b010);
    irqPending = 1'b0; cyc(3);
    chk("R6 waking held", powerState, 3);
    pulseDone();
    chk("R9 back to active", powerState, 0);
    cyc(1);
    chk("R2 re-enter sleep path", kicks(), 3'b100);
    pulseDone();
    chk("R6 sleep again", powerState, 2);
    offSelect = 1'b1; sleepPin = 1'b1; cyc(2);
    chk("R8 sync delay", powerState, 2);
    cyc(1);
    chk("R8 pin inactive wakes", powerState, 3);
    chk("R9 sleep-to-off strobe", kicks(), 3'b001);
    offSelect = 1'b0; pulseDone();
    chk("R9 off reached", powerState, 4);
    sleepPin = 1'b0; irqPending = 1'b1; pulseDone(); cyc(6);
    chk("R9 off is sticky", powerState, 4);
    chk("R9 no strobes in off", kicks(), 0);

    irqPending = 1'b0; polInvert = 1'b1; sleepPin = 1'b0;
    doReset(); cyc(6);
    chk("R3 low pin ignored when inverted", powerState, 0);
    pulseDone();
    chk("R12 done ignored in active", powerState, 0);
    sleepPin = 1'b1; cyc(3);
    chk("R3 high pin sleeps when inverted", powerState, 1);

    // Random phase against the model.
    pend = 0;
    for (int n = 0; n < 4000; n++) begin
      if (n % 500 == 0) begin doReset(); pend = 0; end
      else @(negedge clk);
      chk("R6 state vs model", powerState, mState);
      chk("R10 strobes vs model", kicks(), mKick);
      seqDone = 1'b0;
      if (kicks() != 0) pend = 1 + ($urandom % 5);
      else if (pend > 0) begin pend--; if (pend == 0) seqDone = 1'b1; end
      else if ($urandom % 16 == 0) seqDone = 1'b1;
      if ($urandom % 8 == 0) sleepPin = ~sleepPin;
      if ($urandom % 6 == 0) irqPending = ~irqPending;
      if ($urandom % 40 == 0) sleepMask = ~sleepMask;
      if ($urandom % 60 == 0) polInvert = ~polInvert;
      offSelect = ($urandom % 5 == 0);
    end
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule